// File: doc/BRIEF.md
# RISC Integer Execute Unit with Immediate Extender

This block is the combinational arithmetic and logic stage of a simple three-operand load/store processor. Each cycle it receives two 32-bit register operands, a 16-bit immediate, a 5-bit constant shift count and a 4-bit operation code. It returns a 32-bit result together with a zero flag and a signed-overflow flag in the same cycle. There is no clock, no storage and no handshake: the surrounding pipeline registers the inputs and captures the outputs.

Operations with an immediate form use the immediate, extended to 32 bits, in place of operand B. The extension rule follows the operation class. Arithmetic and compare forms copy bit 15 upward. Logical forms fill with zeros. The upper-immediate load takes its value from the immediate alone and ignores both register operands. Shifts act on operand A by the constant count.

Top module: `rx_alu`

## Requirements
- R1: ADD (code 0) returns A+B and SUB (code 1) returns A-B, both wrapping modulo 2^32.
- R2: AND (code 2), OR (code 3) and NOR (code 4) are bitwise: result bit i depends only on bit i of A and of B.
- R3: ovf_o is 1 only when ADD (0), SUB (1) or ADDI (11) yields a result whose true signed value falls outside -2^31..2^31-1. For every other code it is 0.
- R4: zero_o is 1 exactly when result_o equals zero, for every code.
- R5: SLT (code 5) returns 1 when A is less than B as two's complement, otherwise 0, with bits 31:1 always zero. For A=0xFFFFFFFA and B=0x0000FFFA it returns 1.
- R6: SLTU (code 6) compares A and B as unsigned with the same 0/1 result. For A=0xFFFFFFFA and B=0x0000FFFA it returns 0.
- R7: SLL (code 7) and SRL (code 8) shift A by shamt_in (0..31) and fill vacated bits with 0. 0x12345678 SRL 8 gives 0x00123456.
- R8: SRA (code 9) shifts A right by shamt_in and fills vacated bits with A[31]. 0x92345678 SRA 8 gives 0xFF923456.
- R9: ADDI (11), SLTI (12) and SLTIU (13) use imm_in sign-extended from bit 15 as operand B. SLTIU then compares unsigned.
- R10: ANDI (14) and ORI (15) use imm_in zero-extended as operand B. 0x12345678 ORI 0xFFFF gives 0x1234FFFF, and ANDI 0x0FFF keeps only bits 11:0 of A.
- R11: LUI (code 10) returns imm_in in bits 31:16 and zero in bits 15:0, whatever A and B hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code, values as in the requirements |
| a_in | input | 32 | Register operand A |
| b_in | input | 32 | Register operand B |
| imm_in | input | 16 | Instruction immediate |
| shamt_in | input | 5 | Constant shift count |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result equals zero |
| ovf_o | output | 1 | Signed overflow of add/subtract |

## Verification
The hardest cases to reach from the ports are the overflow boundary and the sign-against-magnitude disagreement between the two compares. Random operands seldom land exactly on 0x7FFFFFFF+1 or -2^31-1, and they seldom pick a negative immediate beside a small positive register. The stimulus therefore drives directed operand pairs at the signed limits, pairs of opposite sign whose signed and unsigned orders disagree, and immediates with bit 15 set for each immediate class. It then adds random operands for every operation code, and a model built from the requirements predicts each result.

// File: rtl/rx_alu_pkg.sv
package rx_alu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_NOR   = 4'd4,
    OP_SLT   = 4'd5,
    OP_SLTU  = 4'd6,
    OP_SLL   = 4'd7,
    OP_SRL   = 4'd8,
    OP_SRA   = 4'd9,
    OP_LUI   = 4'd10,
    OP_ADDI  = 4'd11,
    OP_SLTI  = 4'd12,
    OP_SLTIU = 4'd13,
    OP_ANDI  = 4'd14,
    OP_ORI   = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_SUM,
    SEL_LOGIC,
    SEL_LT_S,
    SEL_LT_U,
    SEL_SHIFT,
    SEL_UPPER
  } res_sel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_NOR
  } logic_fn_e;

  typedef struct packed {
    logic      use_imm;
    logic      imm_signed;
    logic      do_sub;
    logic      ovf_en;
    logic      shr;
    logic      sh_arith;
    logic_fn_e lfn;
    res_sel_e  sel;
  } ctl_t;
endpackage

// File: rtl/rx_imm_ext.sv
module rx_imm_ext #(
  parameter int IW = 16,
  parameter int W  = 32
) (
  input  logic [IW-1:0] imm,
  input  logic          sign_en,
  output logic [W-1:0]  ext,
  output logic [W-1:0]  upper
);
  localparam int PAD = W - IW;

  logic pad_bit;
  assign pad_bit = sign_en & imm[IW-1];
  assign ext     = {{PAD{pad_bit}}, imm};
  assign upper   = {imm, {PAD{1'b0}}};
endmodule

// File: rtl/rx_addsub.sv
module rx_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;
  logic         carry;
  logic         a_msb, b_msb, s_msb;

  assign b_eff = b ^ {W{sub}};
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];
  assign carry = wide[W];

  assign a_msb = a[W-1];
  assign b_msb = b[W-1];
  assign s_msb = sum[W-1];

  // Overflow: operand signs that should give a sign the result lacks.
  always_comb begin
    if (sub) ovf = (a_msb != b_msb) && (s_msb != a_msb);
    else     ovf = (a_msb == b_msb) && (s_msb != a_msb);
  end

  // Compares rely on sub being set by the decoder.
  assign lt_u = ~carry;
  assign lt_s = (a_msb ^ b_msb) ? a_msb : s_msb;
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic          right,
  input  logic          arith,
  output logic [W-1:0]  out
);
  logic fill;
  assign fill = right & arith & val[W-1];

  for (genvar k = 0; k < SW; k++) begin : g_stg
    localparam int D = 1 << k;
    logic [W-1:0] s_in;
    logic [W-1:0] s_out;
    logic [W-1:0] s_shifted;

    if (k == 0) begin : g_first
      assign s_in = val;
    end else begin : g_next
      assign s_in = g_stg[k-1].s_out;
    end

    assign s_shifted = right ? {{D{fill}}, s_in[W-1:D]}
                             : {s_in[W-1-D:0], {D{1'b0}}};
    assign s_out = amt[k] ? s_shifted : s_in;
  end

  assign out = g_stg[SW-1].s_out;
endmodule

// File: rtl/rx_logic_unit.sv
module rx_logic_unit
  import rx_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (fn)
        LG_AND:  y[i] = a[i] & b[i];
        LG_OR:   y[i] = a[i] | b[i];
        default: y[i] = ~(a[i] | b[i]);
      endcase
    end
  end
endmodule

// File: rtl/rx_alu.sv
module rx_alu
  import rx_alu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W
) (
  input  logic [3:0]           op_sel,
  input  logic [W-1:0]         a_in,
  input  logic [W-1:0]         b_in,
  input  logic [IW-1:0]        imm_in,
  input  logic [$clog2(W)-1:0] shamt_in,
  output logic [W-1:0]         result_o,
  output logic                 zero_o,
  output logic                 ovf_o
);
  localparam int SW = $clog2(W);

  alu_op_e      op;
  ctl_t         ctl;
  logic [W-1:0] imm_ext, imm_up, opnd_b;
  logic [W-1:0] sum, lg_y, sh_y;
  logic         add_ovf, lt_s, lt_u;

  assign op = alu_op_e'(op_sel);

  // Decode: one control word per operation code.
  always_comb begin
    ctl = '{use_imm: 1'b0, imm_signed: 1'b1, do_sub: 1'b0, ovf_en: 1'b0,
            shr: 1'b0, sh_arith: 1'b0, lfn: LG_AND, sel: SEL_SUM};
    case (op)
      OP_ADD:   ctl.ovf_en = 1'b1;
      OP_SUB:   begin ctl.do_sub = 1'b1; ctl.ovf_en = 1'b1; end
      OP_AND:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_AND; end
      OP_OR:    begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_OR;  end
      OP_NOR:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_NOR; end
      OP_SLT:   begin ctl.sel = SEL_LT_S; ctl.do_sub = 1'b1; end
      OP_SLTU:  begin ctl.sel = SEL_LT_U; ctl.do_sub = 1'b1; end
      OP_SLL:   ctl.sel = SEL_SHIFT;
      OP_SRL:   begin ctl.sel = SEL_SHIFT; ctl.shr = 1'b1; end
      OP_SRA:   begin ctl.sel = SEL_SHIFT; ctl.shr = 1'b1; ctl.sh_arith = 1'b1; end
      OP_LUI:   ctl.sel = SEL_UPPER;
      OP_ADDI:  begin ctl.use_imm = 1'b1; ctl.ovf_en = 1'b1; end
      OP_SLTI:  begin ctl.use_imm = 1'b1; ctl.sel = SEL_LT_S; ctl.do_sub = 1'b1; end
      OP_SLTIU: begin ctl.use_imm = 1'b1; ctl.sel = SEL_LT_U; ctl.do_sub = 1'b1; end
      OP_ANDI:  begin ctl.use_imm = 1'b1; ctl.imm_signed = 1'b0;
                      ctl.sel = SEL_LOGIC; ctl.lfn = LG_AND; end
      OP_ORI:   begin ctl.use_imm = 1'b1; ctl.imm_signed = 1'b0;
                      ctl.sel = SEL_LOGIC; ctl.lfn = LG_OR; end
      default:  ;
    endcase
  end

  rx_imm_ext #(.IW(IW), .W(W)) u_ext (
    .imm     (imm_in),
    .sign_en (ctl.imm_signed),
    .ext     (imm_ext),
    .upper   (imm_up)
  );

  assign opnd_b = ctl.use_imm ? imm_ext : b_in;

  rx_addsub #(.W(W)) u_add (
    .a    (a_in),
    .b    (opnd_b),
    .sub  (ctl.do_sub),
    .sum  (sum),
    .ovf  (add_ovf),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  rx_logic_unit #(.W(W)) u_lgc (
    .a  (a_in),
    .b  (opnd_b),
    .fn (ctl.lfn),
    .y  (lg_y)
  );

  rx_shifter #(.W(W), .SW(SW)) u_shf (
    .val   (a_in),
    .amt   (shamt_in),
    .right (ctl.shr),
    .arith (ctl.sh_arith),
    .out   (sh_y)
  );

  always_comb begin
    case (ctl.sel)
      SEL_LOGIC: result_o = lg_y;
      SEL_LT_S:  result_o = {{(W-1){1'b0}}, lt_s};
      SEL_LT_U:  result_o = {{(W-1){1'b0}}, lt_u};
      SEL_SHIFT: result_o = sh_y;
      SEL_UPPER: result_o = imm_up;
      default:   result_o = sum;
    endcase
  end

  assign zero_o = (result_o == '0);
  assign ovf_o  = ctl.ovf_en & add_ovf;
endmodule

// File: rtl/rx_alu_chk.sv
module rx_alu_chk
  import rx_alu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W
) (
  input logic [3:0]           op_sel,
  input logic [W-1:0]         a_in,
  input logic [W-1:0]         b_in,
  input logic [IW-1:0]        imm_in,
  input logic [$clog2(W)-1:0] shamt_in,
  input logic [W-1:0]         result_o,
  input logic                 zero_o,
  input logic                 ovf_o
);
  always_comb begin
    // R4: subtract gives zero exactly when the operands match
    if (op_sel == OP_SUB)
      p_sub_zero_r4: assert (zero_o == (a_in == b_in))
        else $error("R4 zero flag wrong for equal-operand subtract");
    // R1: add result minus B recovers A modulo 2^32
    if (op_sel == OP_ADD)
      p_add_wrap_r1: assert (result_o - b_in == a_in)
        else $error("R1 add result inconsistent");
    // R3: no overflow outside the add/subtract codes
    if (op_sel != OP_ADD && op_sel != OP_SUB && op_sel != OP_ADDI)
      p_no_overflow_r3: assert (!ovf_o)
        else $error("R3 overflow on non-arithmetic code");
    // R5/R6: compare results use only bit 0
    if (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI || op_sel == OP_SLTIU)
      p_cmp_upper_r5: assert (result_o[W-1:1] == '0)
        else $error("R5 compare upper bits not zero");
    // R11: upper-immediate low half is zero and high half is the immediate
    if (op_sel == OP_LUI)
      p_upper_imm_r11: assert (result_o[W-IW-1:0] == '0 && result_o[W-1:W-IW] == imm_in)
        else $error("R11 upper immediate malformed");
    // R8: arithmetic right shift of a negative value stays negative
    if (op_sel == OP_SRA && a_in[W-1])
      p_sra_sign_r8: assert (result_o[W-1])
        else $error("R8 sign bit lost");
    // R2: OR result covers every set bit of A
    if (op_sel == OP_OR)
      p_or_cover_r2: assert ((result_o & a_in) == a_in)
        else $error("R2 OR dropped a bit of A");
  end
endmodule

bind rx_alu rx_alu_chk #(.W(W), .IW(IW)) u_chk (.*);

// File: tb/tb_rx_alu.sv
`timescale 1ns/1ps
module tb_rx_alu;
  import rx_alu_pkg::*;

  logic        clk = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [31:0] a_in = '0, b_in = '0;
  logic [15:0] imm_in = '0;
  logic [4:0]  shamt_in = '0;
  logic [31:0] result_o;
  logic        zero_o, ovf_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        z;
    logic        v;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk; // 125 MHz

  rx_alu dut (
    .op_sel(op_sel), .a_in(a_in), .b_in(b_in), .imm_in(imm_in),
    .shamt_in(shamt_in), .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [15:0] imm,
                                 input logic [4:0] sh, input string tag);
    exp_t e;
    logic [31:0] sx, zx;
    longint wide;
    sx = {{16{imm[15]}}, imm};
    zx = {16'h0, imm};
    e.v = 1'b0;
    e.tag = tag;
    case (op)
      4'd0:  begin e.res = a + b; wide = longint'($signed(a)) + longint'($signed(b)); end
      4'd1:  begin e.res = a - b; wide = longint'($signed(a)) - longint'($signed(b)); end
      4'd2:  e.res = a & b;
      4'd3:  e.res = a | b;
      4'd4:  e.res = ~(a | b);
      4'd5:  e.res = {31'h0, $signed(a) < $signed(b)};
      4'd6:  e.res = {31'h0, a < b};
      4'd7:  e.res = a << sh;
      4'd8:  e.res = a >> sh;
      4'd9:  e.res = $unsigned($signed(a) >>> sh);
      4'd10: e.res = {imm, 16'h0};
      4'd11: begin e.res = a + sx; wide = longint'($signed(a)) + longint'($signed(sx)); end
      4'd12: e.res = {31'h0, $signed(a) < $signed(sx)};
      4'd13: e.res = {31'h0, a < sx};
      4'd14: e.res = a & zx;
      default: e.res = a | zx;
    endcase
    if (op == 4'd0 || op == 4'd1 || op == 4'd11)
      e.v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    e.z = (e.res == 32'h0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic [4:0] sh, input string tag);
    @(posedge clk);
    op_sel = op; a_in = a; b_in = b; imm_in = imm; shamt_in = sh;
    sb.push_back(model(op, a, b, imm, sh, tag));
  endtask

  task automatic drive_fixed(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] imm, input logic [4:0] sh,
                             input logic [31:0] want, input string tag);
    exp_t e;
    @(posedge clk);
    op_sel = op; a_in = a; b_in = b; imm_in = imm; shamt_in = sh;
    e = model(op, a, b, imm, sh, tag);
    e.res = want;
    e.z = (want == 32'h0);
    sb.push_back(e);
  endtask

  // Monitor: compare half a cycle after each drive.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (result_o !== e.res || zero_o !== e.z || ovf_o !== e.v) begin
        n_bad++;
        $display("FAIL %s: res=%h z=%b v=%b expected res=%h z=%b v=%b",
                 e.tag, result_o, zero_o, ovf_o, e.res, e.z, e.v);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // reset-like idle state: ADD of zeros, R4 zero flag
    drive(4'd0, 32'h0, 32'h0, 16'h0, 5'd0, "R4 idle add zero");
    // R1 wrap and R3 overflow limits
    drive(4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R1 add wrap");
    drive(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R3 add pos overflow");
    drive(4'd1, 32'h8000_0000, 32'h1, 16'h0, 5'd0, "R3 sub neg overflow");
    drive(4'd1, 32'h0000_0005, 32'h0000_0005, 16'h0, 5'd0, "R4 sub equal zero");
    drive(4'd11, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, "R3 addi overflow");
    drive(4'd11, 32'h0000_0040, 32'h0, 16'hFFCE, 5'd0, "R9 addi negative imm");
    // R2 bitwise
    drive(4'd4, 32'hF0F0_0000, 32'h0F0F_0000, 16'h0, 5'd0, "R2 nor");
    drive(4'd2, 32'hA5A5_5A5A, 32'h0FF0_F00F, 16'h0, 5'd0, "R2 and");
    // R5 / R6 signed vs unsigned disagreement
    drive_fixed(4'd5, 32'hFFFF_FFFA, 32'h0000_FFFA, 16'h0, 5'd0, 32'h1, "R5 slt signed");
    drive_fixed(4'd6, 32'hFFFF_FFFA, 32'h0000_FFFA, 16'h0, 5'd0, 32'h0, "R6 sltu unsigned");
    // R9 compare immediates sign-extended
    drive_fixed(4'd12, 32'h0000_0003, 32'h0, 16'hFFFF, 5'd0, 32'h0, "R9 slti vs -1");
    drive_fixed(4'd13, 32'h0000_0003, 32'h0, 16'hFFFF, 5'd0, 32'h1, "R9 sltiu vs 0xFFFFFFFF");
    // R7 / R8 shifts
    drive_fixed(4'd8, 32'h1234_5678, 32'h0, 16'h0, 5'd8, 32'h0012_3456, "R7 srl 8");
    drive_fixed(4'd7, 32'h1234_5678, 32'h0, 16'h0, 5'd8, 32'h3456_7800, "R7 sll 8");
    drive_fixed(4'd9, 32'h9234_5678, 32'h0, 16'h0, 5'd8, 32'hFF92_3456, "R8 sra 8");
    drive_fixed(4'd9, 32'h8000_0000, 32'h0, 16'h0, 5'd31, 32'hFFFF_FFFF, "R8 sra 31");
    drive_fixed(4'd8, 32'h8000_0000, 32'h0, 16'h0, 5'd31, 32'h0000_0001, "R7 srl 31");
    // R10 zero-extended logical immediates
    drive_fixed(4'd15, 32'h1234_5678, 32'h0, 16'hFFFF, 5'd0, 32'h1234_FFFF, "R10 ori");
    drive_fixed(4'd14, 32'hDEAD_BEEF, 32'h0, 16'h0FFF, 5'd0, 32'h0000_0EEF, "R10 andi 0x0FFF");
    drive_fixed(4'd14, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0, 32'h0000_8000, "R10 andi high bit");
    // R11 upper immediate ignores A and B
    drive_fixed(4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABAB, 5'd3, 32'hABAB_0000, "R11 lui");
    drive_fixed(4'd10, 32'h1234_5678, 32'h0, 16'h0000, 5'd0, 32'h0, "R11 lui zero R4");
    // Random sweep over every code
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'(i % 16);
      drive(op, $urandom, (i % 5 == 0) ? 32'h8000_0000 : $urandom, 16'($urandom),
            5'($urandom), "R1-R11 random sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule